// File: doc/BRIEF.md
# Wrapped Burst Address Generator

This block produces the byte address for every beat of a burst into a byte-addressed memory with a 21-bit address. A burst starts by loading a start address. Each advance strobe then steps the address by one byte. In wrapped mode the address stays inside an aligned power-of-two window, and the window size is chosen at run time. In linear mode the whole address counts up.

A 2-bit length code from a mode register sets the window size. A toggle strobe flips the generator between two states. In one state it follows that code. In the other it uses a fixed 32-byte window. Pages are 512 bytes. The generator raises a one-cycle flag when a step moves the address into a different page, so that the surrounding controller can lower its clock rate for that burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `addr` is 0, `page_cross` is 0, and the window follows `wrap_code` (the toggle state is cleared).
- R2: A `load` puts `start_addr` on `addr` at the next clock edge. An `advance` in the same cycle as a `load` has no effect.
- R3: With `wrap_en`=1, an advance increments only the low k bits of `addr`, modulo 2^k, and leaves bits above k unchanged. The value of k comes from `wrap_code`: 0 selects 16 bytes (k=4), 1 selects 32 bytes (k=5), 2 selects 64 bytes (k=6).
- R4: `wrap_code`=3 selects the 512-byte page window (k=9).
- R5: Each cycle with `toggle`=1 flips the window source between `wrap_code` and a fixed 32-byte window (k=5). The flip takes effect from the next cycle.
- R6: With `wrap_en`=0, an advance adds 1 to the full 21-bit address, and 0x1FFFFF rolls over to 0.
- R7: `page_cross` is 1 for exactly the cycle after an advance that changed `addr[20:9]`. Otherwise it is 0, and it is never 1 after a wrapped advance.
- R8: With neither `load` nor `advance`, `addr` holds its value.
- R9: An advance in the same cycle as a `toggle` uses the window that was active before that toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 21 | Burst start address |
| load | input | 1 | Load start address |
| advance | input | 1 | Step to next beat |
| wrap_code | input | 2 | Window length code from the mode register |
| toggle | input | 1 | Flip window source |
| wrap_en | input | 1 | 1 = wrapped burst, 0 = linear burst |
| addr | output | 21 | Current beat address |
| page_cross | output | 1 | Previous step entered a new page |

## Verification
The bench builds the block with its default parameters: a 21-bit address, a 9-bit page and a 5-bit alternate window. With these values the top of the address space can be reached with a single load, so the 0x1FFFFF rollover and the page-crossing pulse are both exercised. Every window size, including the toggled 32-byte window, is driven from start addresses near the window edges. Toggles that coincide with advances and loads that coincide with advances are mixed in, so the ordering rules are compared cycle by cycle against the behavioural model.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   typedef enum logic [1:0] {
      WIN_16   = 2'd0,
      WIN_32   = 2'd1,
      WIN_64   = 2'd2,
      WIN_PAGE = 2'd3
   } win_code_e;

   localparam int unsigned SHORT_WIN_BASE_BITS = 4;

   // number of low address bits inside the selected window
   function automatic logic [7:0] code_bits(input win_code_e code, input int unsigned page_bits);
      logic [7:0] r;
      case (code)
         WIN_16:  r = 8'(SHORT_WIN_BASE_BITS);
         WIN_32:  r = 8'(SHORT_WIN_BASE_BITS + 1);
         WIN_64:  r = 8'(SHORT_WIN_BASE_BITS + 2);
         default: r = 8'(page_bits);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/burst_win_sel.sv
module burst_win_sel
   import burst_addr_pkg::*;
#(
   parameter int unsigned ADDR_W        = 21,
   parameter int unsigned PAGE_BITS     = 9,
   parameter int unsigned ALT_WIN_BITS  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              toggle,
   input  logic [1:0]        wrap_code,
   output logic [ADDR_W-1:0] win_mask
);
   localparam int unsigned BW = $clog2(ADDR_W + 1);

   logic          alt_q;
   logic [BW-1:0] sel_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      alt_q <= 1'b0;
      else if (toggle) alt_q <= ~alt_q;
   end

   always_comb begin
      if (alt_q) sel_bits = BW'(ALT_WIN_BITS);
      else       sel_bits = BW'(code_bits(win_code_e'(wrap_code), PAGE_BITS));
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      assign win_mask[i] = (BW'(i) < sel_bits);
   end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
   parameter int unsigned ADDR_W    = 21,
   parameter int unsigned PAGE_BITS = 9
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ADDR_W-1:0] win_mask,
   input  logic              wrap_en,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic              nxt_cross
);
   logic [ADDR_W-1:0] inc;

   assign inc      = cur_addr + ADDR_W'(1);
   assign nxt_addr = wrap_en ? ((cur_addr & ~win_mask) | (inc & win_mask)) : inc;

   if (PAGE_BITS < ADDR_W) begin : g_paged
      assign nxt_cross = (nxt_addr[ADDR_W-1:PAGE_BITS] != cur_addr[ADDR_W-1:PAGE_BITS]);
   end else begin : g_single_page
      // the whole space is one page: only the rollover leaves it
      assign nxt_cross = ~wrap_en & (&cur_addr);
   end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
   parameter int unsigned ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] nxt_addr,
   input  logic              nxt_cross,
   output logic [ADDR_W-1:0] addr_q,
   output logic              cross_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cross_q <= 1'b0;
      end else begin
         cross_q <= 1'b0;
         if (load) begin
            addr_q <= start_addr;
         end else if (advance) begin
            addr_q  <= nxt_addr;
            cross_q <= nxt_cross;
         end
      end
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int unsigned ADDR_W       = 21,
   parameter int unsigned PAGE_BITS    = 9,
   parameter int unsigned ALT_WIN_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              load,
   input  logic              advance,
   input  logic [1:0]        wrap_code,
   input  logic              toggle,
   input  logic              wrap_en,
   output logic [ADDR_W-1:0] addr,
   output logic              page_cross
);
   if (PAGE_BITS > ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must not exceed ADDR_W");
   end
   if (PAGE_BITS < 6) begin : g_bad_short
      $error("PAGE_BITS must cover the 64-byte window");
   end
   if (ALT_WIN_BITS > PAGE_BITS || ALT_WIN_BITS == 0) begin : g_bad_alt
      $error("ALT_WIN_BITS must lie in 1..PAGE_BITS");
   end

   logic [ADDR_W-1:0] win_mask;
   logic [ADDR_W-1:0] nxt_addr;
   logic              nxt_cross;

   burst_win_sel #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ALT_WIN_BITS(ALT_WIN_BITS)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .toggle(toggle), .wrap_code(wrap_code), .win_mask(win_mask)
   );

   burst_addr_step #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_step (
      .cur_addr(addr), .win_mask(win_mask), .wrap_en(wrap_en),
      .nxt_addr(nxt_addr), .nxt_cross(nxt_cross)
   );

   burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
      .start_addr(start_addr), .nxt_addr(nxt_addr), .nxt_cross(nxt_cross),
      .addr_q(addr), .cross_q(page_cross)
   );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int unsigned ADDR_W    = 21,
   parameter int unsigned PAGE_BITS = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] start_addr,
   input logic              load,
   input logic              advance,
   input logic              wrap_en,
   input logic [ADDR_W-1:0] addr,
   input logic              page_cross
);
   a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr == $past(start_addr));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(addr) && !page_cross);

   a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && !wrap_en) |=> addr == ADDR_W'($past(addr) + ADDR_W'(1)));

   a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && wrap_en) |=> addr[ADDR_W-1:PAGE_BITS] == $past(addr[ADDR_W-1:PAGE_BITS]));

   a_r7_no_cross_wrapped: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && wrap_en) |=> !page_cross);

   a_r7_cross_at_page_end: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && !wrap_en && (&addr[PAGE_BITS-1:0])) |=> page_cross);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .load(load), .advance(advance),
   .wrap_en(wrap_en), .addr(addr), .page_cross(page_cross)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
   localparam int AW = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          load = 1'b0, advance = 1'b0, toggle = 1'b0, wrap_en = 1'b1;
   logic [1:0]    wrap_code = 2'd3;
   logic [AW-1:0] addr;
   logic          page_cross;

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   string req = "R1";

   int m_addr = 0, m_cross = 0, m_alt = 0;

   always #4 clk = ~clk;

   burst_addr_gen u_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .load(load), .advance(advance),
      .wrap_code(wrap_code), .toggle(toggle), .wrap_en(wrap_en),
      .addr(addr), .page_cross(page_cross)
   );

   task automatic check(string r, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, compare after it
   task automatic cyc(bit ld, bit adv, bit tg, bit we, int code, int sa);
      int bits, len, old;
      load = ld; advance = adv; toggle = tg; wrap_en = we;
      wrap_code = 2'(code); start_addr = AW'(sa);
      @(posedge clk);
      bits = m_alt ? 5 : (code == 3 ? 9 : 4 + code);
      len  = 1 << bits;
      old  = m_addr;
      m_cross = 0;
      if (ld) m_addr = sa;
      else if (adv) begin
         if (we) m_addr = (old / len) * len + ((old % len) + 1) % len;
         else    m_addr = (old + 1) % (1 << AW);
         m_cross = ((old >> 9) != (m_addr >> 9)) ? 1 : 0;
      end
      if (tg) m_alt = 1 - m_alt;
      #2;
      check(req, int'(addr), m_addr, "addr");
      check(req, int'(page_cross), m_cross, "page_cross");
      @(negedge clk);
   endtask

   task automatic burst(int n, bit we, int code);
      for (int i = 0; i < n; i++) cyc(0, 1, 0, we, code, 0);
   endtask

   initial begin
      #50000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      req = "R1";
      check(req, int'(addr), 0, "reset addr");
      check(req, int'(page_cross), 0, "reset cross");
      rst_n = 1'b1;
      @(negedge clk);

      req = "R3"; // 16-byte window from near its edge
      cyc(1, 0, 0, 1, 0, 'h1234B);
      burst(20, 1, 0);
      req = "R3"; // 32 and 64 byte windows
      cyc(1, 0, 0, 1, 1, 'h0A3DC);
      burst(40, 1, 1);
      cyc(1, 0, 0, 1, 2, 'h1FFFBD);
      burst(70, 1, 2);

      req = "R4"; // page window wraps inside 512 bytes, no crossing
      cyc(1, 0, 0, 1, 3, 'h005FD);
      burst(6, 1, 3);

      req = "R5"; // toggle to fixed 32 while code says 64
      cyc(0, 0, 1, 1, 2, 0);
      cyc(1, 0, 0, 1, 2, 'h0071C);
      burst(10, 1, 2);
      req = "R5"; // toggle back to the code
      cyc(0, 0, 1, 1, 2, 0);
      burst(40, 1, 2);

      req = "R9"; // advance and toggle in the same cycle
      cyc(1, 0, 0, 1, 3, 'h0013E);
      cyc(0, 1, 1, 1, 3, 0);
      cyc(0, 1, 0, 1, 3, 0);
      cyc(0, 1, 1, 1, 3, 0);
      burst(4, 1, 3);

      req = "R6"; // linear rollover at top of space
      cyc(1, 0, 0, 0, 0, 'h1FFFFD);
      burst(5, 0, 0);
      req = "R7"; // linear crossing of an interior page
      cyc(1, 0, 0, 0, 0, 'h003FE);
      burst(4, 0, 1);

      req = "R2"; // advance with load is ignored
      cyc(1, 1, 0, 1, 0, 'h04440);
      check(req, int'(addr), 'h04440, "load wins");
      req = "R8";
      cyc(0, 0, 0, 1, 0, 0);
      cyc(0, 0, 0, 0, 1, 0);

      req = "R1"; // reset clears toggle state
      cyc(0, 0, 1, 1, 0, 0);
      rst_n = 1'b0; m_addr = 0; m_alt = 0; m_cross = 0;
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1, 0, 0, 1, 0, 'h0002C);
      burst(6, 1, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule